// File: doc/BRIEF.md
# Bus Request Interrupt Level Mapper

This block sits between a set of bus devices and the processor's priority-interrupt system. Every device slot can post a bus request priority of 4, 5, 6 or 7, or withdraw its request by posting 0. Priorities 4 and 5 are folded onto a programmable "low" interrupt level, and priorities 6 and 7 onto a programmable "high" level. Both levels are supplied from outside as one-hot 7-bit masks, where bit k stands for interrupt level k+1 and all-zero means no level is programmed. Each slot keeps the one-hot level it was mapped to. The block presents the OR of all slots' levels to the processor, with a one-cycle update pulse whenever that combined vector changes.

When the processor services a level, it sends an acknowledge carrying that level's one-hot mask. The block returns the interrupt vector of the lowest-numbered slot whose pending level equals the acknowledged mask, or 0 when no slot matches. Acknowledges and vector responses move over a valid/ready pair. An acknowledge is accepted only while `ack_ready` is high, which happens when no response is waiting or the waiting one is being taken in the same cycle. A response stays on `resp_vec` with `resp_valid` high until the consumer raises `resp_ready`. Device vectors are supplied per slot on an input bus.

Top module: `irq_level_mapper`

## Requirements
- R1: A strobed priority of 4 or 5 on slot i stores the programmed low level as that slot's pending mask, when that level is nonzero. The mask shows on `cpu_req_lvl` after the next rising edge.
- R2: A strobed priority of 6 or 7 stores the programmed high level in the same way, when that level is nonzero.
- R3: A strobed priority of 0 clears the slot's pending mask. `cpu_req_lvl` always equals the OR of all slots' masks, so a level stays asserted while any other slot still holds it. This includes a request on one slot and a withdraw on another in the same cycle: the request keeps the level up.
- R4: A request whose mapped level is all-zero is ignored: the slot's previous pending mask is kept unchanged.
- R5: Strobed priority codes 1, 2 and 3 are illegal. They leave the slot's mask unchanged and raise `req_err` for exactly the cycle after the edge that sampled them.
- R6: `cpu_req_upd` is high in a cycle exactly when `cpu_req_lvl` differs from its value in the previous cycle.
- R7: An accepted acknowledge with a one-hot `ack_level` returns, after the next edge, the `dev_vec` field of the lowest-indexed slot whose pending mask equals `ack_level`. The field for slot i is bits [18*i+17:18*i]. The response is 0 if no slot matches, or if `ack_level` is not one-hot.
- R8: After reset, `cpu_req_lvl`, `cpu_req_upd`, `req_err` and `resp_valid` are 0 and `ack_ready` is 1. While `resp_valid` is high and `resp_ready` is low, `ack_ready` is 0 and `resp_vec` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_level | input | 7 | One-hot level for priorities 4/5; zero = unprogrammed |
| hi_level | input | 7 | One-hot level for priorities 6/7; zero = unprogrammed |
| dev_req_stb | input | 8 | Per-slot request strobe |
| dev_req_pri | input | 24 | Per-slot priority code, slot i at bits [3*i+2:3*i] |
| dev_vec | input | 144 | Per-slot interrupt vector, slot i at bits [18*i+17:18*i] |
| cpu_req_lvl | output | 7 | OR of all pending level masks |
| cpu_req_upd | output | 1 | High when cpu_req_lvl changed this cycle |
| req_err | output | 1 | Illegal priority code seen at the last edge |
| ack_valid | input | 1 | Acknowledge present |
| ack_ready | output | 1 | Acknowledge can be accepted |
| ack_level | input | 7 | One-hot level being acknowledged |
| resp_valid | output | 1 | Vector response present |
| resp_ready | input | 1 | Consumer takes the response |
| resp_vec | output | 18 | Returned interrupt vector |

## Verification
Several checks run on every cycle. Slot masks stay one-hot or zero. A withdraw empties the slot, and an illegal code leaves it as it was. The update pulse appears only when the combined vector moves, and a stalled response keeps its value. The bench covers the rest through its scenarios. These are the mapping of each priority pair to the current programmed level, and the OR across slots after partial withdraws. They also include an ignored request under an unprogrammed level, and the slot-order choice of vector, which becomes visible only through acknowledges.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam int PRI_W = 3;
  typedef logic [PRI_W-1:0] pri_t;

  localparam pri_t PRI_NONE = 3'd0;
  localparam pri_t PRI_LO_A = 3'd4;
  localparam pri_t PRI_LO_B = 3'd5;
  localparam pri_t PRI_HI_A = 3'd6;
  localparam pri_t PRI_HI_B = 3'd7;

  typedef enum logic [1:0] {
    PK_CLEAR,
    PK_LOW,
    PK_HIGH,
    PK_BAD
  } pri_kind_e;

  function automatic pri_kind_e classify(input pri_t p);
    case (p)
      PRI_NONE:           return PK_CLEAR;
      PRI_LO_A, PRI_LO_B: return PK_LOW;
      PRI_HI_A, PRI_HI_B: return PK_HIGH;
      default:            return PK_BAD;
    endcase
  endfunction
endpackage

// File: rtl/irqm_slot.sv
module irqm_slot
  import irqm_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  pri_t             pri,
  input  logic [LVL_W-1:0] lo_lvl,
  input  logic [LVL_W-1:0] hi_lvl,
  output logic [LVL_W-1:0] pend_o,
  output logic             err_o
);
  logic [LVL_W-1:0] pend_q, pend_d;
  logic             bad;
  pri_kind_e        kind;

  always_comb begin
    kind   = classify(pri);
    pend_d = pend_q;
    bad    = 1'b0;
    if (stb) begin
      case (kind)
        PK_CLEAR: pend_d = '0;
        PK_LOW:   if (|lo_lvl) pend_d = lo_lvl;
        PK_HIGH:  if (|hi_lvl) pend_d = hi_lvl;
        default:  bad = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      err_o  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      err_o  <= bad;
    end
  end

  assign pend_o = pend_q;

  // R1/R2: a slot only ever holds one level
  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lo_lvl) && $onehot0(hi_lvl) |=> $onehot0(pend_q));
  // R3: withdraw empties the slot
  p_withdraw_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stb && pri == PRI_NONE |=> pend_q == '0);
  // R5: illegal code keeps the slot
  p_illegal_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stb && pri != PRI_NONE && pri < PRI_LO_A |=> $stable(pend_q) && err_o);
  // R4: unprogrammed low level keeps the slot
  p_nolevel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stb && (pri == PRI_LO_A || pri == PRI_LO_B) && lo_lvl == '0 |=> $stable(pend_q));
endmodule

// File: rtl/irqm_agg.sv
module irqm_agg #(
  parameter int NDEV  = 8,
  parameter int LVL_W = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NDEV*LVL_W-1:0] pend_flat,
  output logic [LVL_W-1:0]      lvl_o,
  output logic                  upd_o
);
  logic [LVL_W-1:0] prev_q;

  always_comb begin
    lvl_o = '0;
    for (int i = 0; i < NDEV; i++) lvl_o |= pend_flat[i*LVL_W +: LVL_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_o;
  end

  assign upd_o = (lvl_o != prev_q);

  // R6: no pulse means the combined vector held still
  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_o |-> $stable(lvl_o));
endmodule

// File: rtl/irqm_vec_sel.sv
module irqm_vec_sel #(
  parameter int NDEV  = 8,
  parameter int LVL_W = 7,
  parameter int VEC_W = 18
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NDEV*LVL_W-1:0] pend_flat,
  input  logic [NDEV*VEC_W-1:0] dev_vec,
  input  logic                  ack_valid,
  output logic                  ack_ready,
  input  logic [LVL_W-1:0]      ack_level,
  output logic                  resp_valid,
  input  logic                  resp_ready,
  output logic [VEC_W-1:0]      resp_vec
);
  logic [VEC_W-1:0] hit;
  logic             take;

  always_comb begin
    hit = '0;
    for (int i = NDEV - 1; i >= 0; i--)
      if (pend_flat[i*LVL_W +: LVL_W] == ack_level) hit = dev_vec[i*VEC_W +: VEC_W];
    if (!$onehot(ack_level)) hit = '0;
  end

  assign ack_ready = !resp_valid || resp_ready;
  assign take      = ack_valid && ack_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_vec   <= '0;
    end else if (take) begin
      resp_valid <= 1'b1;
      resp_vec   <= hit;
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
    end
  end

  // R8: stalled response is held
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_vec));
  // R7: acknowledging nothing yields a zero vector
  p_zero_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take && ack_level == '0 |=> resp_valid && resp_vec == '0);
endmodule

// File: rtl/irq_level_mapper.sv
module irq_level_mapper
  import irqm_pkg::*;
#(
  parameter int NDEV  = 8,
  parameter int LVL_W = 7,
  parameter int VEC_W = 18
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LVL_W-1:0]      lo_level,
  input  logic [LVL_W-1:0]      hi_level,
  input  logic [NDEV-1:0]       dev_req_stb,
  input  logic [NDEV*PRI_W-1:0] dev_req_pri,
  input  logic [NDEV*VEC_W-1:0] dev_vec,
  output logic [LVL_W-1:0]      cpu_req_lvl,
  output logic                  cpu_req_upd,
  output logic                  req_err,
  input  logic                  ack_valid,
  output logic                  ack_ready,
  input  logic [LVL_W-1:0]      ack_level,
  output logic                  resp_valid,
  input  logic                  resp_ready,
  output logic [VEC_W-1:0]      resp_vec
);
  localparam int PEND_W = NDEV * LVL_W;

  logic [PEND_W-1:0] pend_flat;
  logic [NDEV-1:0]   slot_err;

  for (genvar g = 0; g < NDEV; g++) begin : g_slot
    irqm_slot #(.LVL_W(LVL_W)) slot_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb    (dev_req_stb[g]),
      .pri    (dev_req_pri[g*PRI_W +: PRI_W]),
      .lo_lvl (lo_level),
      .hi_lvl (hi_level),
      .pend_o (pend_flat[g*LVL_W +: LVL_W]),
      .err_o  (slot_err[g])
    );
  end

  assign req_err = |slot_err;

  irqm_agg #(.NDEV(NDEV), .LVL_W(LVL_W)) agg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_flat (pend_flat),
    .lvl_o     (cpu_req_lvl),
    .upd_o     (cpu_req_upd)
  );

  irqm_vec_sel #(.NDEV(NDEV), .LVL_W(LVL_W), .VEC_W(VEC_W)) sel_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_flat  (pend_flat),
    .dev_vec    (dev_vec),
    .ack_valid  (ack_valid),
    .ack_ready  (ack_ready),
    .ack_level  (ack_level),
    .resp_valid (resp_valid),
    .resp_ready (resp_ready),
    .resp_vec   (resp_vec)
  );
endmodule

// File: tb/irq_level_mapper_tb.sv
module irq_level_mapper_tb_top;
  localparam int N = 8;
  localparam int L = 7;
  localparam int V = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [L-1:0]   lo_level = '0, hi_level = '0, ack_level = '0;
  logic [N-1:0]   dev_req_stb = '0;
  logic [N*3-1:0] dev_req_pri = '0;
  logic [N*V-1:0] dev_vec;
  logic [L-1:0]   cpu_req_lvl;
  logic cpu_req_upd, req_err, ack_valid = 1'b0, ack_ready, resp_valid, resp_ready = 1'b0;
  logic [V-1:0]   resp_vec;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [L-1:0] m_pend [N];
  logic [L-1:0] m_prev;

  always #10 clk = ~clk;

  irq_level_mapper dut_i (.*);

  function automatic logic [V-1:0] vec_of(int i);
    return V'(18'o1000 + i * 4 + 1);
  endfunction

  function automatic logic [L-1:0] m_or();
    logic [L-1:0] r = '0;
    for (int i = 0; i < N; i++) r |= m_pend[i];
    return r;
  endfunction

  function automatic logic [V-1:0] m_vec(logic [L-1:0] lv);
    if (!$onehot(lv)) return '0;
    for (int i = 0; i < N; i++) if (m_pend[i] == lv) return vec_of(i);
    return '0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive strobes on slots given by mask with codes in pri; check after edge
  task automatic post(logic [N-1:0] mask, logic [N*3-1:0] pri);
    logic bad = 1'b0;
    @(negedge clk);
    dev_req_stb = mask;
    dev_req_pri = pri;
    m_prev = m_or();
    for (int i = 0; i < N; i++) begin
      if (mask[i]) begin
        logic [2:0] p = pri[i*3 +: 3];
        if (p == 0) m_pend[i] = '0;
        else if (p == 4 || p == 5) begin if (|lo_level) m_pend[i] = lo_level; end
        else if (p >= 6) begin if (|hi_level) m_pend[i] = hi_level; end
        else bad = 1'b1;
      end
    end
    @(negedge clk);
    dev_req_stb = '0;
    check("R1/R2/R3 cpu_req_lvl", 32'(cpu_req_lvl), 32'(m_or()));
    check("R6 cpu_req_upd", 32'(cpu_req_upd), 32'(m_or() != m_prev));
    check("R5 req_err", 32'(req_err), 32'(bad));
  endtask

  task automatic one(int slot, logic [2:0] p);
    logic [N*3-1:0] pr = '0;
    pr[slot*3 +: 3] = p;
    post(N'(1) << slot, pr);
  endtask

  task automatic ack(logic [L-1:0] lv, string req);
    logic [V-1:0] e = m_vec(lv);
    @(negedge clk);
    check("R8 ack_ready idle", 32'(ack_ready), 32'd1);
    ack_valid = 1'b1;
    ack_level = lv;
    resp_ready = 1'b0;
    @(negedge clk);
    ack_valid = 1'b0;
    check("R8 resp_valid", 32'(resp_valid), 32'd1);
    check(req, 32'(resp_vec), 32'(e));
    @(negedge clk);
    check("R8 ack_ready stalled", 32'(ack_ready), 32'd0);
    check("R8 resp_vec held", 32'(resp_vec), 32'(e));
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
    check("R8 resp drained", 32'(resp_valid), 32'd0);
  endtask

  function automatic logic [L-1:0] rnd_lvl();
    int r = $urandom % 8;
    return (r == 0) ? '0 : L'(1) << (r - 1);
  endfunction

  function automatic logic [2:0] rnd_pri();
    int r = $urandom % 10;
    case (r)
      0, 9: return 3'd0;
      2, 3: return 3'd4;
      4:    return 3'd5;
      5:    return 3'd6;
      6, 7: return 3'd7;
      8:    return 3'(1 + $urandom % 3);
      default: return 3'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) begin
      m_pend[i] = '0;
      dev_vec[i*V +: V] = vec_of(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 reset lvl", 32'(cpu_req_lvl), 0);
    check("R8 reset upd", 32'(cpu_req_upd), 0);
    check("R8 reset err", 32'(req_err), 0);
    check("R8 reset resp_valid", 32'(resp_valid), 0);
    check("R8 reset ack_ready", 32'(ack_ready), 1);

    // R4: unprogrammed levels ignore requests
    one(2, 3'd4);
    one(2, 3'd7);
    ack(7'b0000001, "R4 nothing recorded");
    lo_level = 7'b0000100;
    hi_level = 7'b0100000;
    one(3, 3'd5);   // R1
    one(5, 3'd4);   // R1
    one(1, 3'd6);   // R2
    ack(7'b0000100, "R7 lowest slot wins");
    ack(7'b0100000, "R2/R7 high level vector");
    lo_level = '0;
    one(3, 3'd4);   // R4: keeps old mask
    ack(7'b0000100, "R4 previous mask kept");
    one(3, 3'd0);   // R3: slot 5 still holds level
    ack(7'b0000100, "R3 remaining slot");
    one(6, 3'd2);   // R5
    lo_level = 7'b0000100;
    post(8'b0000_0101, {15'd0, 3'd4, 3'd0, 3'd0}); // slot2 req, slot0 withdraw
    post(8'b0010_0100, {6'd0, 3'd0, 9'd0, 3'd0, 6'd0}); // R3 mix
    ack(7'b0000011, "R7 non-one-hot ack");
    ack(7'b1000000, "R7 no match");

    for (int it = 0; it < 400; it++) begin
      if ($urandom % 16 == 0) begin
        lo_level = rnd_lvl();
        hi_level = rnd_lvl();
      end
      if ($urandom % 4 == 0) begin
        logic [N-1:0]   m = N'($urandom);
        logic [N*3-1:0] p = '0;
        for (int i = 0; i < N; i++) p[i*3 +: 3] = rnd_pri();
        post(m, p);
      end else begin
        one($urandom % N, rnd_pri());
      end
      if ($urandom % 3 == 0) ack(L'(1) << ($urandom % L), "R7 random ack");
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule